// File: doc/BRIEF.md
# I2C Message Sequencing Engine

This block carries one I2C message from start to finish on top of a step-wise I2C master core. The core does the bus timing. After each bus step it raises an event strobe with an 8-bit status code. The engine reacts to each event with exactly one action: a start condition, a byte to transmit, permission to receive the next byte (with the ACK control bit), or a stop condition. The engine never inspects the bus itself. The status code alone decides the next move, together with its own count of bytes still to go.

A message is launched with a one-cycle start pulse. The pulse carries these inputs:
- a 10-bit target address and a 10-bit addressing flag;
- read and reverse-direction flags;
- a flag that skips the start and address phases;
- a byte count;
- a timeout limit in clock cycles.

Bytes to write enter on a valid/ready pair. Received bytes leave as single-cycle valid pulses. Completion is a one-cycle done pulse carrying a result code.

If the cycle limit runs out, the engine reports a timeout and parks in an aborting state. The next event from the core then turns into a stop.

Top module: `i2c_msg_seq`

## Requirements
- R1: With 7-bit addressing, the first address byte is the address's low seven bits shifted left by one, with the direction bit in bit 0. It is sent as an action of kind 2 (send) on status 0x08 or 0x10.
- R2: With 10-bit addressing, the first address byte is 0xF0 OR (address bits 9:8 shifted left by one) OR the direction bit. On status 0x18 or 0x40, the second byte, address bits 7:0, is sent.
- R3: The direction bit is 1 for a read and 0 for a write. Setting the reverse flag inverts it.
- R4: On status 0x18 (7-bit), 0xD0 or 0x28, the next write byte is sent if bytes remain. Otherwise the engine issues a stop (action kind 4) and pulses done with result 0 (ok). A non-stalled message starts with action kind 1 (start).
- R5: On a read, each receive action (kind 3) sets the ACK control bit to 0 exactly when one byte remains to be received, and to 1 otherwise. Status 0x50 pushes the received byte and continues. Status 0x58 pushes the byte, stops, and finishes with result 0.
- R6: Status 0x20, 0x30 or 0x48 causes a stop and finishes with result 1 (no device).
- R7: Any status code outside the table causes a stop and finishes with result 2 (bus error). So does an event while the engine is waiting for a write byte.
- R8: With the no-start flag, no start or address action occurs. A write first waits for a data byte. A read immediately issues a receive action. A zero-length no-start message stops and finishes with result 0 at once.
- R9: Every stop action clears the interrupt-enable control bit. A message start sets both control bits to 1. An event that arrives while the engine is idle produces a stop action and no done pulse.
- R10: A cycle counter is cleared at message start. If it reaches the programmed limit before completion and no event is present, done pulses with result 3 (timeout), busy stays high, and no action is issued. The next event then issues a stop and returns the engine to idle.
- R11: A zero-length read issues a stop and finishes with result 0 on the address acknowledge (0x40 for 7-bit, 0xE0 for 10-bit). No receive action is issued.
- R12: While waiting for a write byte, wr_ready is high. A handshake sends that byte (kind 2) in the following cycle. No action occurs while wr_valid stays low.
- R13: A start pulse while busy is ignored. The running message keeps its latched address and count.
- R14: Reset clears all outputs to 0. Every action, data and completion output is registered: it changes in the cycle after the input that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | One-cycle message launch, taken only when idle |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | 10-bit addressing |
| msg_rd | input | 1 | Read message |
| msg_rev | input | 1 | Invert the direction bit |
| msg_nostart | input | 1 | Skip start and address phases |
| msg_len | input | LEN_W | Byte count |
| msg_tmo | input | TMO_W | Timeout limit in cycles |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Engine is taking a write byte |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | Received byte pulse |
| core_evt | input | 1 | Master core step finished |
| core_status | input | 8 | Status code of that step |
| core_rxbyte | input | 8 | Byte received by the core |
| act_valid | output | 1 | Action pulse |
| act_kind | output | 3 | 1 start, 2 send, 3 receive, 4 stop |
| act_byte | output | 8 | Byte of the last send action |
| ctl_ack | output | 1 | ACK control bit level |
| ctl_ien | output | 1 | Interrupt-enable control bit level |
| busy | output | 1 | Message in progress or aborting |
| done | output | 1 | Completion pulse |
| result | output | 2 | 0 ok, 1 no device, 2 bus error, 3 timeout |

## Verification
The hardest situation to reach is the aborting state. The limit must expire while the core stays silent. Only after that may a late event arrive, and it must then become a stop that returns the engine to idle without a second done. The bench launches a message with a short limit, withholds the core's answer after the first address byte, lets the counter run out, and only then injects a stale status. A behavioural reference model follows every cycle, so the exact expiry cycle is checked along with the late stop.

// File: rtl/i2c_msg_seq_pkg.sv
package i2c_msg_seq_pkg;

  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_START = 3'd1,
    ACT_SEND  = 3'd2,
    ACT_RECV  = 3'd3,
    ACT_STOP  = 3'd4
  } act_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_NODEV  = 2'd1,
    RES_BUSERR = 2'd2,
    RES_TMO    = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSTART,
    ST_WADR1,
    ST_WADR2,
    ST_WSACK,
    ST_WSDATA,
    ST_NEEDTX,
    ST_ABORT
  } st_e;

  localparam logic [7:0] SC_START     = 8'h08;
  localparam logic [7:0] SC_RSTART    = 8'h10;
  localparam logic [7:0] SC_WADR_ACK  = 8'h18;
  localparam logic [7:0] SC_WADR_NAK  = 8'h20;
  localparam logic [7:0] SC_WDAT_ACK  = 8'h28;
  localparam logic [7:0] SC_WDAT_NAK  = 8'h30;
  localparam logic [7:0] SC_RADR_ACK  = 8'h40;
  localparam logic [7:0] SC_RADR_NAK  = 8'h48;
  localparam logic [7:0] SC_RDAT_ACK  = 8'h50;
  localparam logic [7:0] SC_RDAT_NAK  = 8'h58;
  localparam logic [7:0] SC_WADR2_ACK = 8'hD0;
  localparam logic [7:0] SC_RADR2_ACK = 8'hE0;

endpackage

// File: rtl/i2c_msg_seq_addr.sv
module i2c_msg_seq_addr (
  input  logic [9:0] addr,
  input  logic       ten,
  input  logic       rd,
  input  logic       rev,
  output logic [7:0] first_byte,
  output logic [7:0] second_byte
);
  logic dir;

  // R3: direction bit, inverted by the reverse flag
  assign dir = rd ^ rev;

  // R1 / R2: address byte formation
  always_comb begin
    if (ten) begin
      first_byte  = {5'b11110, addr[9:8], dir};
      second_byte = addr[7:0];
    end else begin
      first_byte  = {addr[6:0], dir};
      second_byte = 8'h00;
    end
  end
endmodule

// File: rtl/i2c_msg_seq_timer.sv
module i2c_msg_seq_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             hit
);
  logic [TMO_W-1:0] cnt_q, cnt_n;
  logic [TMO_W-1:0] lim_q, lim_n;
  logic             cnt_en;

  assign cnt_en = clr | run;

  always_comb begin
    cnt_n = cnt_q;
    lim_n = lim_q;
    if (clr) begin
      cnt_n = '0;
      lim_n = limit;
    end else if (run) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
      lim_q <= lim_n;
    end
  end

  // R10: expiry while a message is running
  assign hit = run && (cnt_q == lim_q);
endmodule

// File: rtl/i2c_msg_seq_ctrl.sv
module i2c_msg_seq_ctrl
  import i2c_msg_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ten,
  input  logic             rd,
  input  logic             nostart,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       a1,
  input  logic [7:0]       a2,
  input  logic             evt,
  input  logic [7:0]       status,
  input  logic [7:0]       rxbyte,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             tmo_hit,
  output logic             run,
  output logic             clr,
  output logic             act_valid,
  output logic [2:0]       act_kind,
  output logic [7:0]       act_byte,
  output logic             ctl_ack,
  output logic             ctl_ien,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  st_e              st_q, st_n;
  logic [LEN_W-1:0] left_q, left_n;
  logic [7:0]       a1_q, a1_n, a2_q, a2_n;
  logic             ten_q, ten_n;
  logic             av_q, av_n;
  act_e             kind_q, kind_n;
  logic [7:0]       byte_q, byte_n;
  logic             ack_q, ack_n, ien_q, ien_n;
  logic             done_q, done_n;
  res_e             res_q, res_n;
  logic             rdv_q, rdv_n;
  logic [7:0]       rdd_q, rdd_n;

  logic fin, send, recv, recv_ack, path_wr, path_rd, stop_only;
  res_e fin_code;
  logic [7:0] sbyte;

  assign run = (st_q != ST_IDLE) && (st_q != ST_ABORT);

  always_comb begin
    st_n = st_q;     left_n = left_q;  a1_n = a1_q;  a2_n = a2_q;  ten_n = ten_q;
    av_n = 1'b0;     kind_n = kind_q;  byte_n = byte_q;
    ack_n = ack_q;   ien_n = ien_q;    done_n = 1'b0; res_n = res_q;
    rdv_n = 1'b0;    rdd_n = rdd_q;
    fin = 1'b0;      fin_code = RES_OK; clr = 1'b0;  wr_ready = 1'b0;
    send = 1'b0;     recv = 1'b0;      recv_ack = 1'b1; sbyte = 8'h00;
    path_wr = 1'b0;  path_rd = 1'b0;   stop_only = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (evt) begin
          stop_only = 1'b1;                       // R9: stray event
        end else if (start) begin
          clr = 1'b1;
          a1_n = a1; a2_n = a2; ten_n = ten; left_n = len;
          ack_n = 1'b1; ien_n = 1'b1;
          if (nostart && (len == '0)) begin
            fin = 1'b1;                           // R8
          end else if (nostart && rd) begin
            recv = 1'b1; recv_ack = (len != ONE); st_n = ST_WSDATA;
          end else if (nostart) begin
            st_n = ST_NEEDTX;
          end else begin
            av_n = 1'b1; kind_n = ACT_START; st_n = ST_WSTART;
          end
        end
      end
      ST_ABORT: begin
        if (evt) begin
          stop_only = 1'b1;                       // R10: late event
          st_n = ST_IDLE;
        end
      end
      ST_NEEDTX: begin
        if (evt) begin
          fin = 1'b1; fin_code = RES_BUSERR;      // R7
        end else if (tmo_hit) begin
          done_n = 1'b1; res_n = RES_TMO; st_n = ST_ABORT;
        end else begin
          wr_ready = 1'b1;                        // R12
          if (wr_valid) begin
            send = 1'b1; sbyte = wr_data; left_n = left_q - ONE; st_n = ST_WSACK;
          end
        end
      end
      default: begin
        if (evt) begin
          case (status)
            SC_START, SC_RSTART: begin
              send = 1'b1; sbyte = a1_q; st_n = ST_WADR1;
            end
            SC_WADR_ACK: begin
              if (ten_q) begin send = 1'b1; sbyte = a2_q; st_n = ST_WADR2; end
              else path_wr = 1'b1;
            end
            SC_WADR2_ACK, SC_WDAT_ACK: path_wr = 1'b1;
            SC_RADR_ACK: begin
              if (ten_q) begin send = 1'b1; sbyte = a2_q; st_n = ST_WADR2; end
              else path_rd = 1'b1;
            end
            SC_RADR2_ACK: path_rd = 1'b1;
            SC_RDAT_ACK: begin
              if (left_q == '0) begin
                fin = 1'b1; fin_code = RES_BUSERR;
              end else begin
                rdv_n = 1'b1; rdd_n = rxbyte; left_n = left_q - ONE;
                recv = 1'b1; recv_ack = (left_q != TWO); st_n = ST_WSDATA;
              end
            end
            SC_RDAT_NAK: begin
              rdv_n = 1'b1; rdd_n = rxbyte; fin = 1'b1;
            end
            SC_WADR_NAK, SC_WDAT_NAK, SC_RADR_NAK: begin
              fin = 1'b1; fin_code = RES_NODEV;
            end
            default: begin
              fin = 1'b1; fin_code = RES_BUSERR;
            end
          endcase
          if (path_wr) begin
            if (left_q != '0) st_n = ST_NEEDTX;
            else fin = 1'b1;
          end
          if (path_rd) begin
            if (left_q == '0) fin = 1'b1;         // R11
            else begin
              recv = 1'b1; recv_ack = (left_q != ONE); st_n = ST_WSDATA;
            end
          end
        end else if (tmo_hit) begin
          done_n = 1'b1; res_n = RES_TMO; st_n = ST_ABORT;
        end
      end
    endcase
    if (send) begin
      av_n = 1'b1; kind_n = ACT_SEND; byte_n = sbyte;
    end
    if (recv) begin
      av_n = 1'b1; kind_n = ACT_RECV; ack_n = recv_ack;   // R5
    end
    if (stop_only || fin) begin
      av_n = 1'b1; kind_n = ACT_STOP; ien_n = 1'b0;
    end
    if (fin) begin
      done_n = 1'b1; res_n = fin_code; st_n = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  left_q <= '0;    a1_q <= '0;    a2_q <= '0;   ten_q <= 1'b0;
      av_q <= 1'b0;     kind_q <= ACT_NONE; byte_q <= '0;
      ack_q <= 1'b0;    ien_q <= 1'b0;   done_q <= 1'b0; res_q <= RES_OK;
      rdv_q <= 1'b0;    rdd_q <= '0;
    end else begin
      st_q <= st_n;     left_q <= left_n; a1_q <= a1_n;  a2_q <= a2_n;  ten_q <= ten_n;
      av_q <= av_n;     kind_q <= kind_n; byte_q <= byte_n;
      ack_q <= ack_n;   ien_q <= ien_n;   done_q <= done_n; res_q <= res_n;
      rdv_q <= rdv_n;   rdd_q <= rdd_n;
    end
  end

  assign act_valid = av_q;
  assign act_kind  = kind_q;
  assign act_byte  = byte_q;
  assign ctl_ack   = ack_q;
  assign ctl_ien   = ien_q;
  assign rd_data   = rdd_q;
  assign rd_valid  = rdv_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign result    = res_q;

  // R6 R7: a non-timeout completion always comes with a stop and leaves idle
  a_r6_finish_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (res_q != RES_TMO)) |-> (av_q && (kind_q == ACT_STOP) && (st_q == ST_IDLE)));

  // R10: expiry without an event parks the engine in the aborting state
  a_r10_tmo_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !evt) |=> ((st_q == ST_ABORT) && done_q && (res_q == RES_TMO) && !av_q));

  // R5: a byte delivered as the engine drops to idle is the final, successful one
  a_r5_final_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rdv_q && (st_q == ST_IDLE)) |-> (done_q && (res_q == RES_OK)));
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq #(
  parameter int LEN_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic [9:0]       msg_addr,
  input  logic             msg_ten,
  input  logic             msg_rd,
  input  logic             msg_rev,
  input  logic             msg_nostart,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [TMO_W-1:0] msg_tmo,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             core_evt,
  input  logic [7:0]       core_status,
  input  logic [7:0]       core_rxbyte,
  output logic             act_valid,
  output logic [2:0]       act_kind,
  output logic [7:0]       act_byte,
  output logic             ctl_ack,
  output logic             ctl_ien,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);
  logic [7:0] first_byte, second_byte;
  logic       tmo_hit, tmr_run, tmr_clr;

  i2c_msg_seq_addr u_addr (
    .addr        (msg_addr),
    .ten         (msg_ten),
    .rd          (msg_rd),
    .rev         (msg_rev),
    .first_byte  (first_byte),
    .second_byte (second_byte)
  );

  i2c_msg_seq_timer #(.TMO_W(TMO_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .limit (msg_tmo),
    .hit   (tmo_hit)
  );

  i2c_msg_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (msg_start),
    .ten       (msg_ten),
    .rd        (msg_rd),
    .nostart   (msg_nostart),
    .len       (msg_len),
    .a1        (first_byte),
    .a2        (second_byte),
    .evt       (core_evt),
    .status    (core_status),
    .rxbyte    (core_rxbyte),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .tmo_hit   (tmo_hit),
    .run       (tmr_run),
    .clr       (tmr_clr),
    .act_valid (act_valid),
    .act_kind  (act_kind),
    .act_byte  (act_byte),
    .ctl_ack   (ctl_ack),
    .ctl_ien   (ctl_ien),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .done      (done),
    .result    (result)
  );

  // R12: an accepted write byte is the next send action
  a_r12_send_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (act_valid && (act_kind == 3'd2) && (act_byte == $past(wr_data))));
endmodule

// File: tb/i2c_msg_seq_tb.sv
module i2c_msg_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msg_start = 0, msg_ten = 0, msg_rd = 0, msg_rev = 0, msg_nostart = 0;
  logic [9:0] msg_addr = '0;
  logic [7:0] msg_len = '0;
  logic [15:0] msg_tmo = 16'd1000;
  logic [7:0] wr_data = '0;
  logic       wr_valid = 0;
  logic       wr_ready, rd_valid, act_valid, ctl_ack, ctl_ien, busy, done;
  logic [7:0] rd_data, act_byte;
  logic [2:0] act_kind;
  logic [1:0] result;
  logic       core_evt = 0;
  logic [7:0] core_status = '0, core_rxbyte = '0;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  i2c_msg_seq u_dut (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_addr(msg_addr),
    .msg_ten(msg_ten), .msg_rd(msg_rd), .msg_rev(msg_rev), .msg_nostart(msg_nostart),
    .msg_len(msg_len), .msg_tmo(msg_tmo), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .core_evt(core_evt),
    .core_status(core_status), .core_rxbyte(core_rxbyte), .act_valid(act_valid),
    .act_kind(act_kind), .act_byte(act_byte), .ctl_ack(ctl_ack), .ctl_ien(ctl_ien),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phases: 0 idle, 1..5 waiting on core, 6 waiting for write byte, 7 aborting
  int m_ph = 0, m_left = 0, m_cnt = 0, m_tmo = 0, m_a1 = 0, m_a2 = 0;
  bit m_ten = 0;
  bit e_av = 0, e_ack = 0, e_ien = 0, e_done = 0, e_rdv = 0;
  int e_kind = 0, e_byte = 0, e_res = 0, e_rdd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_cnt = 0; m_tmo = 0; m_a1 = 0; m_a2 = 0; m_ten = 0;
      e_av = 0; e_ack = 0; e_ien = 0; e_done = 0; e_rdv = 0;
      e_kind = 0; e_byte = 0; e_res = 0; e_rdd = 0;
    end else begin
      bit running;
      int fin, path, dir;
      running = (m_ph >= 1 && m_ph <= 6);
      fin = -1; path = 0;
      e_av = 0; e_done = 0; e_rdv = 0;
      if (m_ph == 0) begin
        if (core_evt) begin e_av = 1; e_kind = 4; e_ien = 0; end
        else if (msg_start) begin
          m_cnt = 0; m_tmo = msg_tmo; m_ten = msg_ten; m_left = msg_len;
          e_ack = 1; e_ien = 1;
          dir = (msg_rd != msg_rev) ? 1 : 0;
          if (msg_ten) begin m_a1 = 240 + 2 * msg_addr[9:8] + dir; m_a2 = msg_addr[7:0]; end
          else begin m_a1 = 2 * msg_addr[6:0] + dir; m_a2 = 0; end
          if (msg_nostart && msg_len == 0) fin = 0;
          else if (msg_nostart && msg_rd) begin e_av = 1; e_kind = 3; e_ack = (msg_len != 1); m_ph = 5; end
          else if (msg_nostart) m_ph = 6;
          else begin e_av = 1; e_kind = 1; m_ph = 1; end
        end
      end else if (m_ph == 7) begin
        if (core_evt) begin e_av = 1; e_kind = 4; e_ien = 0; m_ph = 0; end
      end else if (core_evt) begin
        if (m_ph == 6) fin = 2;
        else case (core_status)
          8'h08, 8'h10: begin e_av = 1; e_kind = 2; e_byte = m_a1; m_ph = 2; end
          8'h18: if (m_ten) begin e_av = 1; e_kind = 2; e_byte = m_a2; m_ph = 3; end else path = 1;
          8'hD0, 8'h28: path = 1;
          8'h40: if (m_ten) begin e_av = 1; e_kind = 2; e_byte = m_a2; m_ph = 3; end else path = 2;
          8'hE0: path = 2;
          8'h50: if (m_left == 0) fin = 2;
                 else begin
                   e_rdv = 1; e_rdd = core_rxbyte; m_left--;
                   e_av = 1; e_kind = 3; e_ack = (m_left != 1); m_ph = 5;
                 end
          8'h58: begin e_rdv = 1; e_rdd = core_rxbyte; fin = 0; end
          8'h20, 8'h30, 8'h48: fin = 1;
          default: fin = 2;
        endcase
        if (path == 1) begin if (m_left > 0) m_ph = 6; else fin = 0; end
        if (path == 2) begin
          if (m_left == 0) fin = 0;
          else begin e_av = 1; e_kind = 3; e_ack = (m_left != 1); m_ph = 5; end
        end
      end else if (running && m_cnt == m_tmo) begin
        e_done = 1; e_res = 3; m_ph = 7;
      end else if (m_ph == 6 && wr_valid) begin
        e_av = 1; e_kind = 2; e_byte = wr_data; m_left--; m_ph = 4;
      end
      if (fin >= 0) begin
        e_av = 1; e_kind = 4; e_ien = 0; e_done = 1; e_res = fin; m_ph = 0;
      end
      if (running) m_cnt++;
    end
  end

  // R14: per-cycle comparison of all registered outputs
  always @(negedge clk) begin
    if (rst_n) begin
      bit ok;
      ok = (act_valid == e_av) && (act_byte == e_byte[7:0]) && (ctl_ack == e_ack) &&
           (ctl_ien == e_ien) && (done == e_done) && (result == e_res[1:0]) &&
           (rd_valid == e_rdv) && (rd_data == e_rdd[7:0]) && (busy == (m_ph != 0)) &&
           (!e_av || act_kind == e_kind[2:0]);
      chk(ok, "R14 model", {act_valid, act_kind, act_byte, done, result, busy},
          {e_av, e_kind[2:0], e_byte[7:0], e_done, e_res[1:0], (m_ph != 0)});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic launch(input logic [9:0] a, input bit ten, input bit rd, input bit rev,
                        input bit ns, input int len, input int tmo);
    @(negedge clk);
    msg_addr = a; msg_ten = ten; msg_rd = rd; msg_rev = rev; msg_nostart = ns;
    msg_len = len[7:0]; msg_tmo = tmo[15:0]; msg_start = 1;
    @(negedge clk);
    msg_start = 0;
  endtask

  task automatic evt(input logic [7:0] s, input logic [7:0] rx);
    @(negedge clk);
    core_evt = 1; core_status = s; core_rxbyte = rx;
    @(negedge clk);
    core_evt = 0;
  endtask

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (act_valid && act_kind == 3'd2) break;
    end
    wr_valid = 0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R14 actual=0x0 expected=0x1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !act_valid && !done && !ctl_ien && result == 0, "R14 reset",
        {busy, act_valid, done, ctl_ien}, 0);

    // 7-bit write, two bytes
    launch(10'h05A, 0, 0, 0, 0, 2, 1000);
    chk(act_valid && act_kind == 3'd1 && ctl_ien && ctl_ack, "R4 start action", act_kind, 1);
    evt(8'h08, 8'h00);
    chk(act_valid && act_kind == 3'd2 && act_byte == 8'hB4, "R1 7-bit write addr", act_byte, 8'hB4);
    evt(8'h18, 8'h00);
    chk(!act_valid, "R12 no action before byte", act_valid, 0);
    idle_cycles(4);
    chk(wr_ready && !act_valid && busy, "R12 stall with ready high", {wr_ready, act_valid}, 2);
    put_byte(8'hA5);
    chk(act_byte == 8'hA5, "R4 first data", act_byte, 8'hA5);
    evt(8'h28, 8'h00);
    put_byte(8'h3C);
    chk(act_byte == 8'h3C, "R4 second data", act_byte, 8'h3C);
    evt(8'h28, 8'h00);
    chk(act_valid && act_kind == 3'd4 && done && result == 0 && !busy, "R4 write finish",
        {act_kind, result}, {3'd4, 2'd0});
    chk(!ctl_ien, "R9 stop clears ien", ctl_ien, 0);

    // 7-bit read, three bytes
    launch(10'h021, 0, 1, 0, 0, 3, 1000);
    evt(8'h08, 8'h00);
    chk(act_byte == 8'h43, "R3 read dir bit", act_byte, 8'h43);
    evt(8'h40, 8'h00);
    chk(act_valid && act_kind == 3'd3 && ctl_ack, "R5 first recv acks", {act_kind, ctl_ack}, {3'd3, 1'b1});
    evt(8'h50, 8'h11);
    chk(rd_valid && rd_data == 8'h11 && ctl_ack, "R5 byte1 and ack", rd_data, 8'h11);
    evt(8'h50, 8'h22);
    chk(rd_valid && rd_data == 8'h22 && !ctl_ack && act_kind == 3'd3, "R5 last byte nack", ctl_ack, 0);
    evt(8'h58, 8'h33);
    chk(rd_valid && rd_data == 8'h33 && done && result == 0 && act_kind == 3'd4, "R5 final byte",
        rd_data, 8'h33);

    // reverse direction, then no device
    launch(10'h021, 0, 1, 1, 0, 1, 1000);
    evt(8'h10, 8'h00);
    chk(act_byte == 8'h42, "R3 reverse flag", act_byte, 8'h42);
    evt(8'h48, 8'h00);
    chk(done && result == 1 && act_kind == 3'd4, "R6 no device", result, 1);

    // 10-bit write, then NACK on data
    launch(10'h2B7, 1, 0, 0, 0, 1, 1000);
    evt(8'h08, 8'h00);
    chk(act_byte == 8'hF4, "R2 10-bit first byte", act_byte, 8'hF4);
    evt(8'h18, 8'h00);
    chk(act_valid && act_byte == 8'hB7, "R2 10-bit second byte", act_byte, 8'hB7);
    evt(8'hD0, 8'h00);
    put_byte(8'h99);
    evt(8'h30, 8'h00);
    chk(done && result == 1, "R6 data nack", result, 1);

    // 10-bit zero-length read
    launch(10'h1C5, 1, 1, 0, 0, 0, 1000);
    evt(8'h08, 8'h00);
    chk(act_byte == 8'hF3, "R2 10-bit read first", act_byte, 8'hF3);
    evt(8'h40, 8'h00);
    chk(act_byte == 8'hC5, "R2 10-bit read second", act_byte, 8'hC5);
    evt(8'hE0, 8'h00);
    chk(done && result == 0 && act_kind == 3'd4 && !rd_valid, "R11 zero read 10-bit", act_kind, 4);

    // 7-bit zero-length read
    launch(10'h033, 0, 1, 0, 0, 0, 1000);
    evt(8'h08, 8'h00);
    evt(8'h40, 8'h00);
    chk(done && result == 0 && act_kind == 3'd4, "R11 zero read 7-bit", act_kind, 4);

    // unknown status
    launch(10'h010, 0, 0, 0, 0, 1, 1000);
    evt(8'h38, 8'h00);
    chk(done && result == 2 && act_kind == 3'd4, "R7 bus error", result, 2);

    // no-start write, event while waiting for byte
    launch(10'h010, 0, 0, 0, 1, 2, 1000);
    chk(!act_valid && busy && wr_ready, "R8 no-start write waits", act_valid, 0);
    put_byte(8'h5E);
    evt(8'h28, 8'h00);
    evt(8'h28, 8'h00);
    chk(done && result == 2, "R7 event while waiting", result, 2);

    // no-start read of one byte
    launch(10'h010, 0, 1, 0, 1, 1, 1000);
    chk(act_valid && act_kind == 3'd3 && !ctl_ack, "R8 no-start read", {act_kind, ctl_ack}, {3'd3, 1'b0});
    evt(8'h58, 8'h7E);
    chk(rd_data == 8'h7E && done && result == 0, "R8 no-start read done", rd_data, 8'h7E);

    // no-start zero length
    launch(10'h010, 0, 0, 0, 1, 0, 1000);
    chk(done && result == 0 && act_kind == 3'd4 && !busy, "R8 no-start empty", act_kind, 4);

    // stray event while idle
    evt(8'h08, 8'h00);
    chk(act_valid && act_kind == 3'd4 && !done, "R9 idle event stop", {act_kind, done}, {3'd4, 1'b0});

    // start while busy is ignored
    launch(10'h011, 0, 0, 0, 0, 0, 1000);
    launch(10'h07F, 0, 1, 0, 0, 5, 1000);
    evt(8'h08, 8'h00);
    chk(act_byte == 8'h22, "R13 start ignored", act_byte, 8'h22);
    evt(8'h18, 8'h00);
    chk(done && result == 0, "R13 original count kept", result, 0);

    // timeout then late event
    launch(10'h044, 0, 0, 0, 0, 1, 20);
    evt(8'h08, 8'h00);
    for (int i = 0; i < 100; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done && result == 3 && busy && !act_valid, "R10 timeout", result, 3);
    idle_cycles(3);
    chk(busy && !act_valid, "R10 aborting holds", busy, 1);
    evt(8'h18, 8'h00);
    chk(act_valid && act_kind == 3'd4 && !busy && !done, "R10 late event stop", act_kind, 4);

    idle_cycles(3);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule